// File: doc/BRIEF.md
# Multiple Header Error Log

This block holds the uncorrectable error state of one link-layer function. It keeps a 32-bit uncorrectable status word, a 5-bit pointer to the bit of the error that was logged first, a four-dword header log, a four-dword prefix log and a flag that shows the prefix log holds data. Each incoming error record carries one status bit, a header-valid flag, a prefix-present flag, four header dwords and four prefix dwords. A record either goes straight into the log or, while multiple header recording is enabled and the first logged error is still pending, waits in a first-in first-out queue of pending records.

Software clears status bits with write-one-to-clear writes. When the bit under the pointer is cleared, the oldest queued record moves into the log. If there is no queued record, or recording is off, the log is emptied instead. While recording is on, the status bits of queued records are set again after every status write, so they cannot be lost. If a record cannot be queued because the queue is full, the block raises a one-cycle overflow pulse that asks the neighbouring logic to report a header-log-overflow correctable error.

Top module: `mhr_err_log`

## Requirements
- R1: After a synchronous active-high reset, the status word, pointer, prefix flag, both logs and the overflow pulse are all zero.
- R2: A record whose status field is zero or has more than one bit set is ignored. Status, pointer and logs are unchanged.
- R3: An accepted record always sets its bit in the status word. It is written into the log directly when recording is disabled or when the status bit under the current pointer is clear. The pointer then holds the index of the record's bit, counted from bit 0.
- R4: With header-valid set, log dword i (bits 32i+31..32i) is input dword i with its four bytes reversed, so 0x11223344 reads as 0x44332211. With header-valid clear, the header log is zero.
- R5: The prefix log, byte-reversed in the same way, and the prefix flag are loaded only when the record's prefix-present flag and the prefix-capability input are both high. Otherwise both are zero.
- R6: When recording is enabled and the bit under the pointer is set, an accepted record is queued and the log is left unchanged.
- R7: A record that would be queued while DEPTH records are already waiting is dropped, and the overflow output is high for the one cycle after it. The queue count never exceeds DEPTH.
- R8: A status write clears every bit written as 1. If this clears the bit under the pointer while recording is disabled or the queue is empty, the pointer, prefix flag and both logs become zero.
- R9: If the write clears the bit under the pointer while recording is enabled and the queue is not empty, the oldest queued record is formatted into the log. Records leave in arrival order.
- R10: While recording is enabled, every status write sets again the status bits of all records that were queued before the write, including the one moved into the log.
- R11: A status write that leaves the bit under the pointer set while recording is disabled discards every queued record.
- R12: When a record and a status write arrive in the same cycle, the write is applied first and the record is judged against the state that results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mhr_en | input | 1 | Multiple header recording enable |
| pfx_cap | input | 1 | Function supports end-to-end prefixes |
| rec_valid | input | 1 | Error record present this cycle |
| rec_status | input | 32 | One-hot status bit of the record |
| rec_hdr_valid | input | 1 | Header dwords are meaningful |
| rec_pfx_present | input | 1 | Prefix dwords are meaningful |
| rec_hdr | input | 128 | Header dwords, dword i at bits 32i+31..32i |
| rec_pfx | input | 128 | Prefix dwords, same layout |
| sts_wr_valid | input | 1 | Write to the status word this cycle |
| sts_wr_clear | input | 32 | Write data, ones clear status bits |
| unc_status | output | 32 | Uncorrectable status word |
| first_ptr | output | 5 | Bit index of the logged error |
| pfx_logged | output | 1 | Prefix log holds a prefix |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| ovf_pulse | output | 1 | One-cycle header-log overflow request |

## Verification
The bench builds the block with a queue depth of 4, which lets a handful of records fill the queue. That brings the overflow drop and the draining of a completely full queue within reach of a short directed sequence. A table sequence drives records and clearing writes with recording switched on and off. It follows pointer, status and header log through queueing, in-order promotion, sticky re-assertion and queue discard. Directed tests cover byte order, prefix gating, the overflow and a record that arrives in the same cycle as a write.

// File: rtl/mhr_log_pkg.sv
package mhr_log_pkg;

    localparam int STS_W    = 32;
    localparam int PTR_W    = $clog2(STS_W);
    localparam int DWORD_W  = 32;
    localparam int LOG_DW   = 4;
    localparam int LOG_W    = DWORD_W * LOG_DW;

    typedef struct packed {
        logic [STS_W-1:0] status;
        logic             hdr_valid;
        logic             pfx_present;
        logic [LOG_W-1:0] hdr;
        logic [LOG_W-1:0] pfx;
    } err_rec_t;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             pfx_bit;
        logic [LOG_W-1:0] hdr_log;
        logic [LOG_W-1:0] pfx_log;
    } log_img_t;

    function automatic logic sts_is_onehot(input logic [STS_W-1:0] s);
        return (s != '0) && ((s & (s - STS_W'(1))) == '0);
    endfunction

    function automatic logic [PTR_W-1:0] sts_index(input logic [STS_W-1:0] s);
        logic [PTR_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < STS_W; i++) begin
            if (s[i]) idx = PTR_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [LOG_W-1:0] swap_dwords(input logic [LOG_W-1:0] d);
        logic [LOG_W-1:0] r;
        for (int i = 0; i < LOG_DW; i++) begin
            for (int b = 0; b < 4; b++) begin
                r[i*DWORD_W + b*8 +: 8] = d[i*DWORD_W + (3-b)*8 +: 8];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mhr_fmt.sv
module mhr_fmt
    import mhr_log_pkg::*;
(
    input  err_rec_t rec,
    input  logic     pfx_cap,
    output log_img_t img
);

    logic pfx_take;

    always_comb begin
        pfx_take    = rec.pfx_present && pfx_cap;
        img.ptr     = sts_index(rec.status);
        img.hdr_log = rec.hdr_valid ? swap_dwords(rec.hdr) : '0;
        img.pfx_bit = pfx_take;
        img.pfx_log = pfx_take ? swap_dwords(rec.pfx) : '0;
    end

endmodule

// File: rtl/mhr_fifo.sv
module mhr_fifo
    import mhr_log_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         flush,
    input  err_rec_t                     push_rec,
    output err_rec_t                     head_rec,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [STS_W-1:0]             sticky_or
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    err_rec_t           mem [DEPTH];
    logic [IDX_W-1:0]   rd_q, wr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [STS_W-1:0]   term [DEPTH];

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
        return (int'(p) == DEPTH-1) ? '0 : p + IDX_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wrap_inc(wr_q);
            if (pop)  rd_q <= wrap_inc(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_q] <= push_rec;
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            int offs;
            always_comb begin
                offs    = (i >= int'(rd_q)) ? (i - int'(rd_q)) : (i + DEPTH - int'(rd_q));
                term[i] = (offs < int'(cnt_q)) ? mem[i].status : '0;
            end
        end
    endgenerate

    always_comb begin
        sticky_or = '0;
        for (int i = 0; i < DEPTH; i++) sticky_or |= term[i];
    end

    assign head_rec = mem[rd_q];
    assign count    = cnt_q;

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);

    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (int'(cnt_q) < DEPTH));

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0));

    assert_flush_alone_R11: assert property (@(posedge clk) disable iff (rst)
        flush |-> !push && !pop);

endmodule

// File: rtl/mhr_err_log.sv
module mhr_err_log
    import mhr_log_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          mhr_en,
    input  logic          pfx_cap,
    input  logic          rec_valid,
    input  logic [31:0]   rec_status,
    input  logic          rec_hdr_valid,
    input  logic          rec_pfx_present,
    input  logic [127:0]  rec_hdr,
    input  logic [127:0]  rec_pfx,
    input  logic          sts_wr_valid,
    input  logic [31:0]   sts_wr_clear,
    output logic [31:0]   unc_status,
    output logic [4:0]    first_ptr,
    output logic          pfx_logged,
    output logic [127:0]  hdr_log,
    output logic [127:0]  pfx_log,
    output logic          ovf_pulse
);

    localparam int CNT_W = $clog2(DEPTH+1);

    err_rec_t          in_rec, q_head;
    log_img_t          in_img, head_img, cur_img, w_img, nxt_img;
    logic [STS_W-1:0]  status_q, w_status, status_nxt, q_sticky;
    logic [CNT_W-1:0]  q_count, cnt_after;
    logic              q_push, q_pop, q_flush;
    logic              sel_cleared, rec_ok, to_queue, ovf_nxt, ovf_q;

    assign in_rec = '{status: rec_status, hdr_valid: rec_hdr_valid,
                      pfx_present: rec_pfx_present, hdr: rec_hdr, pfx: rec_pfx};

    mhr_fmt u_fmt_in   (.rec(in_rec), .pfx_cap(pfx_cap), .img(in_img));
    mhr_fmt u_fmt_head (.rec(q_head), .pfx_cap(pfx_cap), .img(head_img));

    mhr_fifo #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(q_push), .pop(q_pop), .flush(q_flush),
        .push_rec(in_rec), .head_rec(q_head), .count(q_count), .sticky_or(q_sticky)
    );

    always_comb begin
        // status write is applied first
        w_status = status_q;
        if (sts_wr_valid) w_status = status_q & ~sts_wr_clear;
        sel_cleared = sts_wr_valid && !w_status[cur_img.ptr];
        q_pop   = sel_cleared && mhr_en && (q_count != '0);
        q_flush = sts_wr_valid && !sel_cleared && !mhr_en;
        if (sts_wr_valid && mhr_en) w_status = w_status | q_sticky;

        w_img = cur_img;
        if (q_pop)            w_img = head_img;
        else if (sel_cleared) w_img = '0;

        cnt_after = q_flush ? '0 : (q_count - CNT_W'(q_pop));

        // then the incoming record
        rec_ok   = rec_valid && sts_is_onehot(rec_status);
        to_queue = rec_ok && mhr_en && w_status[w_img.ptr];
        q_push   = to_queue && (int'(cnt_after) < DEPTH);
        ovf_nxt  = to_queue && !(int'(cnt_after) < DEPTH);

        nxt_img    = (rec_ok && !to_queue) ? in_img : w_img;
        status_nxt = w_status | (rec_ok ? rec_status : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            cur_img  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            status_q <= status_nxt;
            cur_img  <= nxt_img;
            ovf_q    <= ovf_nxt;
        end
    end

    assign unc_status = status_q;
    assign first_ptr  = cur_img.ptr;
    assign pfx_logged = cur_img.pfx_bit;
    assign hdr_log    = cur_img.hdr_log;
    assign pfx_log    = cur_img.pfx_log;
    assign ovf_pulse  = ovf_q;

    assert_bad_rec_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !sts_is_onehot(rec_status) && !sts_wr_valid)
        |=> ($stable(unc_status) && $stable(first_ptr) && $stable(hdr_log)));

    assert_status_set_R3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && sts_is_onehot(rec_status))
        |=> ((unc_status & $past(rec_status)) != '0));

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ($past(rec_valid) && $past(mhr_en)));

    assert_log_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_cleared && !rec_valid && (!mhr_en || q_count == '0))
        |=> (first_ptr == '0 && hdr_log == '0 && pfx_log == '0 && !pfx_logged));

    assert_pop_loads_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_cleared && mhr_en && q_count != '0 && !rec_valid)
        |=> (first_ptr == $past(head_img.ptr)));

    assert_discard_R11: assert property (@(posedge clk) disable iff (rst)
        (sts_wr_valid && !sel_cleared && !mhr_en) |=> (q_count == '0));

endmodule

// File: tb/test_mhr_err_log.sv
`timescale 1ns/1ps
module test_mhr_err_log;

    localparam int NSTEP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mhr_en = 1'b0;
    logic          pfx_cap = 1'b1;
    logic          rec_valid = 1'b0;
    logic [31:0]   rec_status = '0;
    logic          rec_hdr_valid = 1'b0;
    logic          rec_pfx_present = 1'b0;
    logic [127:0]  rec_hdr = '0;
    logic [127:0]  rec_pfx = '0;
    logic          sts_wr_valid = 1'b0;
    logic [31:0]   sts_wr_clear = '0;
    logic [31:0]   unc_status;
    logic [4:0]    first_ptr;
    logic          pfx_logged;
    logic [127:0]  hdr_log;
    logic [127:0]  pfx_log;
    logic          ovf_pulse;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mhr_err_log #(.DEPTH(4)) i_mhr_err_log (
        .clk(clk), .rst(rst), .mhr_en(mhr_en), .pfx_cap(pfx_cap),
        .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr_valid(rec_hdr_valid),
        .rec_pfx_present(rec_pfx_present), .rec_hdr(rec_hdr), .rec_pfx(rec_pfx),
        .sts_wr_valid(sts_wr_valid), .sts_wr_clear(sts_wr_clear),
        .unc_status(unc_status), .first_ptr(first_ptr), .pfx_logged(pfx_logged),
        .hdr_log(hdr_log), .pfx_log(pfx_log), .ovf_pulse(ovf_pulse)
    );

    // stimulus table: kind 0 = record, 1 = status write
    localparam bit          T_KIND [NSTEP] = '{0,0,0,1,1,1,1,0,0,0,0,1,0,1,1,1};
    localparam bit          T_MHR  [NSTEP] = '{1,1,1,1,1,1,1,1,1,0,0,0,1,0,1,1};
    localparam logic [31:0] T_DATA [NSTEP] = '{32'h8, 32'h20, 32'h80, 32'h20,
        32'h08, 32'h20, 32'h80, 32'h3, 32'h0, 32'h1, 32'h200, 32'h200,
        32'h80000000, 32'h0, 32'h1, 32'h80000000};
    localparam logic [31:0] T_EXP_STS [NSTEP] = '{32'h8, 32'h28, 32'hA8, 32'hA8,
        32'hA0, 32'h80, 32'h0, 32'h0, 32'h0, 32'h1, 32'h201, 32'h1,
        32'h80000001, 32'h80000001, 32'h80000000, 32'h0};
    localparam int T_EXP_PTR [NSTEP] = '{3,3,3,3,5,7,0,0,0,0,9,0,0,0,0,0};
    localparam int T_EXP_SRC [NSTEP] = '{1,1,1,1,2,3,0,0,0,10,11,0,0,0,0,0};

    function automatic logic [127:0] hdr_of(input int step);
        logic [127:0] h;
        for (int j = 0; j < 4; j++) h[32*j +: 32] = {8'(step), 8'(j), 16'hC3A5};
        return h;
    endfunction

    function automatic logic [127:0] rev_bytes(input logic [127:0] d);
        logic [127:0] r;
        for (int j = 0; j < 4; j++)
            r[32*j +: 32] = {d[32*j +: 8], d[32*j+8 +: 8], d[32*j+16 +: 8], d[32*j+24 +: 8]};
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_rec(input logic en, input logic [31:0] sts, input logic hv,
                            input logic pf, input logic [127:0] h, input logic [127:0] p);
        @(negedge clk);
        mhr_en = en; rec_valid = 1'b1; rec_status = sts;
        rec_hdr_valid = hv; rec_pfx_present = pf; rec_hdr = h; rec_pfx = p;
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic send_wr(input logic en, input logic [31:0] clr);
        @(negedge clk);
        mhr_en = en; sts_wr_valid = 1'b1; sts_wr_clear = clr;
        @(negedge clk);
        sts_wr_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "status", 128'(unc_status), 128'h0);
        check("R1", "pointer", 128'(first_ptr), 128'h0);
        check("R1", "prefix flag", 128'(pfx_logged), 128'h0);
        check("R1", "header log", hdr_log, 128'h0);
        check("R1", "prefix log", pfx_log, 128'h0);
        check("R1", "overflow", 128'(ovf_pulse), 128'h0);

        // table walk: R2 R3 R6 R8 R9 R10 R11
        for (int s = 0; s < NSTEP; s++) begin
            logic [127:0] exp_h;
            if (T_KIND[s] == 1'b0)
                send_rec(T_MHR[s], T_DATA[s], 1'b1, 1'b0, hdr_of(s+1), 128'h0);
            else
                send_wr(T_MHR[s], T_DATA[s]);
            exp_h = (T_EXP_SRC[s] == 0) ? 128'h0 : rev_bytes(hdr_of(T_EXP_SRC[s]));
            check($sformatf("R2 R3 R6 R8 R9 R10 R11 step %0d", s+1), "status",
                  128'(unc_status), 128'(T_EXP_STS[s]));
            check($sformatf("R3 R9 step %0d", s+1), "pointer",
                  128'(first_ptr), 128'(T_EXP_PTR[s]));
            check($sformatf("R6 R9 step %0d", s+1), "header log", hdr_log, exp_h);
            check($sformatf("R7 step %0d", s+1), "overflow idle", 128'(ovf_pulse), 128'h0);
        end

        // R4 byte order and R5 prefix gating
        do_reset();
        pfx_cap = 1'b1;
        send_rec(1'b1, 32'h4, 1'b0, 1'b1, 128'hFFFF, {96'h0, 32'h11223344});
        check("R4", "header zeroed", hdr_log, 128'h0);
        check("R5", "prefix log", pfx_log, {96'h0, 32'h44332211});
        check("R5", "prefix flag", 128'(pfx_logged), 128'h1);
        send_wr(1'b1, 32'h4);
        check("R8", "prefix flag cleared", 128'(pfx_logged), 128'h0);
        pfx_cap = 1'b0;
        send_rec(1'b1, 32'h4, 1'b1, 1'b1, {96'h0, 32'h11223344}, 128'h55);
        check("R4", "byte reversed", hdr_log, {96'h0, 32'h44332211});
        check("R5", "prefix log without cap", pfx_log, 128'h0);
        check("R5", "prefix flag without cap", 128'(pfx_logged), 128'h0);
        pfx_cap = 1'b1;

        // R7 overflow with depth 4
        do_reset();
        send_rec(1'b1, 32'h2, 1'b1, 1'b0, hdr_of(50), 128'h0);
        for (int b = 2; b <= 5; b++)
            send_rec(1'b1, 32'h1 << b, 1'b1, 1'b0, hdr_of(50+b), 128'h0);
        check("R7", "overflow idle while queue fills", 128'(ovf_pulse), 128'h0);
        send_rec(1'b1, 32'h40, 1'b1, 1'b0, hdr_of(56), 128'h0);
        check("R7", "overflow pulse", 128'(ovf_pulse), 128'h1);
        check("R7", "status keeps dropped bit", 128'(unc_status), 128'h7E);
        check("R7", "log unchanged", hdr_log, rev_bytes(hdr_of(50)));
        @(negedge clk);
        check("R7", "pulse lasts one cycle", 128'(ovf_pulse), 128'h0);
        for (int b = 1; b <= 4; b++) begin
            send_wr(1'b1, 32'h1 << b);
            check("R9", "drain pointer", 128'(first_ptr), 128'(b+1));
            check("R9", "drain header", hdr_log, rev_bytes(hdr_of(51+b)));
        end
        send_wr(1'b1, 32'h20);
        check("R7", "dropped record never logged", 128'(first_ptr), 128'h0);
        check("R8", "log cleared after drain", hdr_log, 128'h0);
        check("R10", "status after drain", 128'(unc_status), 128'h40);

        // R12 record and write in the same cycle
        do_reset();
        send_rec(1'b1, 32'h10, 1'b1, 1'b0, hdr_of(70), 128'h0);
        @(negedge clk);
        mhr_en = 1'b1;
        sts_wr_valid = 1'b1; sts_wr_clear = 32'h10;
        rec_valid = 1'b1; rec_status = 32'h100; rec_hdr_valid = 1'b1;
        rec_pfx_present = 1'b0; rec_hdr = hdr_of(71);
        @(negedge clk);
        sts_wr_valid = 1'b0; rec_valid = 1'b0;
        check("R12", "pointer", 128'(first_ptr), 128'h8);
        check("R12", "header", hdr_log, rev_bytes(hdr_of(71)));
        check("R12", "status", 128'(unc_status), 128'h100);

        finish_run();
    end

endmodule